// File: doc/BRIEF.md
# Interrupt-Triggered DMA Channel Dispatcher

This block keeps one pending flag for each interrupt source and hands those flags out to a small group of DMA channels. Each source is known by its vector number. Software gives each channel a start vector and a transfer count. When the flag of that vector is pending and the channel is armed, the block sends the channel a one-cycle transfer request. In the same clock edge it consumes the flag and lowers the channel's count by one.

When the count runs out, the channel raises a sticky end-of-transfer interrupt and wipes its own start vector, which disarms it. If several channels hold the same vector, the lowest-numbered armed channel takes every request until it disarms. The next channel with that vector then takes over, so channels can be chained on one source.

A flag that no armed channel owns is passed to the CPU as an ordinary interrupt request. A write-only clear register drops a single pending flag, chosen by its vector number.

Top module: `dma_trigger_dispatch`

## Requirements
- R1: A write to address 0x00 whose data bits [5:0] hold a nonzero vector n clears pending flag n at the next edge. Writing vector 0 there changes nothing. Address 0x00 always reads 0.
- R2: `irq_in[n]` high at an edge, for n from 1 to 63, sets pending flag n. `irq_in[0]` is ignored. Bit n of `cpu_irq` equals pending flag n unless some armed channel holds vector n, in which case bit n is 0.
- R3: A channel is armed when its start vector (address 0x10+c, bits [5:0]) is nonzero and its count (address 0x20+c) is nonzero. When an armed channel wins the pending flag of its vector, `dma_req[c]` is high for the cycle after that edge, and the flag is cleared at the same edge.
- R4: Each request issued to a channel lowers that channel's count by exactly one. No request is ever issued to a channel whose count is 0.
- R5: When a request takes a channel's count from 1 to 0, bit c of `eot_irq` becomes 1 and the channel's start vector becomes 0 at that same edge.
- R6: Among armed channels holding the same pending vector, only the lowest-numbered channel gets the request. Channels with different vectors can receive requests in the same cycle.
- R7: After the lower channel has disarmed itself, the next request from the shared vector goes to the next higher-numbered channel that holds that vector.
- R8: A new `irq_in[n]` at the same edge as a clear-register write of n, or at the same edge as the consumption of flag n, leaves flag n set.
- R9: `eot_irq` bits are readable at address 0x30 (bit c is channel c). Writing 1 to bit c there clears that bit. A new end-of-transfer on the same edge as that clear leaves the bit set.
- R10: A software write to a channel's start vector or count at the same edge as a request update of that register takes effect, and the request update is dropped. Reads of unmapped addresses return 0.
- R11: After reset, all pending flags, start vectors, counts, `eot_irq` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request strobes, one per vector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Combinational read data |
| dma_req | output | 4 | One-cycle transfer request per channel |
| eot_irq | output | 4 | Sticky end-of-transfer interrupt per channel |
| cpu_irq | output | 64 | Pending flags not owned by an armed channel |

## Verification
Two updates of a pending flag can land on the same edge. One is the setting of a flag by a new request. The other is its removal, either by a clear-register write or by a channel consuming it. The bench provokes both pairings on purpose. It judges the result by the flag staying visible, either on `cpu_irq` or as a second back-to-back `dma_req`. A second collision, a terminal request against a software write to the end-of-transfer status or to the start vector, is placed in the exact edge of the final transfer. The bench then checks that the set-wins and write-wins rules hold. Every cycle is also compared against a behavioural model of the flags and channels.

// File: rtl/dtd_pkg.sv
package dtd_pkg;

  localparam int ADDR_W = 8;

  localparam logic [7:0] A_CLR  = 8'h00;
  localparam logic [3:0] A_VEC_HI = 4'h1;
  localparam logic [3:0] A_CNT_HI = 4'h2;
  localparam logic [7:0] A_EOT  = 8'h30;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CLR,
    RK_VEC,
    RK_CNT,
    RK_EOT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  // Map a register address onto a register kind and channel index.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int nch);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.idx  = a[3:0];
    if (a == A_CLR)
      s.kind = RK_CLR;
    else if (a == A_EOT)
      s.kind = RK_EOT;
    else if (a[7:4] == A_VEC_HI && int'(a[3:0]) < nch)
      s.kind = RK_VEC;
    else if (a[7:4] == A_CNT_HI && int'(a[3:0]) < nch)
      s.kind = RK_CNT;
    return s;
  endfunction

endpackage

// File: rtl/dtd_regs.sv
module dtd_regs
  import dtd_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int VEC_W  = 6,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [NUM_CH-1:0]              grant,
  output logic [NUM_CH-1:0][VEC_W-1:0]   vec,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
  output logic [NUM_CH-1:0]              eot,
  output logic [NUM_CH-1:0]              vec_wr,
  output logic [NUM_CH-1:0]              cnt_wr,
  output logic [NUM_CH-1:0]              last,
  output logic                           clr_stb,
  output logic [VEC_W-1:0]               clr_vec,
  output logic [DATA_W-1:0]              rd_data
);

  // Count after one accepted request.
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  // True when the accepted request is the final one.
  function automatic logic is_final(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  reg_sel_t wsel, rsel;
  logic     eot_wr;

  always_comb begin
    wsel    = decode_addr(wr_addr, NUM_CH);
    rsel    = decode_addr(rd_addr, NUM_CH);
    eot_wr  = wr_en && (wsel.kind == RK_EOT);
    clr_vec = wr_data[VEC_W-1:0];
    clr_stb = wr_en && (wsel.kind == RK_CLR) && (wr_data[VEC_W-1:0] != '0);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign vec_wr[c] = wr_en && (wsel.kind == RK_VEC) && (wsel.idx == 4'(c));
    assign cnt_wr[c] = wr_en && (wsel.kind == RK_CNT) && (wsel.idx == 4'(c));
    assign last[c]   = grant[c] && is_final(cnt[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec[c] <= '0;
        cnt[c] <= '0;
        eot[c] <= 1'b0;
      end else begin
        if (vec_wr[c])      vec[c] <= wr_data[VEC_W-1:0];
        else if (last[c])   vec[c] <= '0;

        if (cnt_wr[c])      cnt[c] <= wr_data[CNT_W-1:0];
        else if (grant[c])  cnt[c] <= cnt_step(cnt[c]);

        if (last[c])                     eot[c] <= 1'b1;
        else if (eot_wr && wr_data[c])   eot[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rsel.kind)
      RK_EOT: rd_data[NUM_CH-1:0] = eot;
      RK_VEC: begin
        for (int c = 0; c < NUM_CH; c++)
          if (rsel.idx == 4'(c)) rd_data[VEC_W-1:0] = vec[c];
      end
      RK_CNT: begin
        for (int c = 0; c < NUM_CH; c++)
          if (rsel.idx == 4'(c)) rd_data[CNT_W-1:0] = cnt[c];
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dtd_arbiter.sv
module dtd_arbiter #(
  parameter int NUM_CH  = 4,
  parameter int VEC_W   = 6,
  parameter int CNT_W   = 16,
  parameter int NUM_VEC = 64
) (
  input  logic [NUM_CH-1:0][VEC_W-1:0] vec,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input  logic [NUM_VEC-1:0]           pend,
  output logic [NUM_CH-1:0]            armed,
  output logic [NUM_CH-1:0]            grant,
  output logic [NUM_VEC-1:0]           consume,
  output logic [NUM_VEC-1:0]           own
);

  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] shadow;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      armed[c] = (vec[c] != '0) && (cnt[c] != '0);
      hit[c]   = armed[c] && pend[vec[c]];
    end
  end

  // A lower-numbered hit on the same vector hides this channel.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_prio
    if (c == 0) begin : g_first
      assign shadow[c] = 1'b0;
    end else begin : g_rest
      logic [c-1:0] lower;
      for (genvar j = 0; j < c; j++) begin : g_low
        assign lower[j] = hit[j] && (vec[j] == vec[c]);
      end
      assign shadow[c] = |lower;
    end
  end

  assign grant = hit & ~shadow;

  always_comb begin
    consume = '0;
    own     = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant[c]) consume[vec[c]] = 1'b1;
      if (armed[c]) own[vec[c]]     = 1'b1;
    end
  end

endmodule

// File: rtl/dtd_flags.sv
module dtd_flags #(
  parameter int VEC_W   = 6,
  parameter int NUM_VEC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_in,
  input  logic               clr_stb,
  input  logic [VEC_W-1:0]   clr_vec,
  input  logic [NUM_VEC-1:0] consume,
  input  logic [NUM_VEC-1:0] own,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] cpu_irq
);

  logic [NUM_VEC-1:0] clr_mask;
  logic [NUM_VEC-1:0] set_mask;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign clr_mask[v] = clr_stb && (clr_vec == VEC_W'(v));
  end

  // Vector zero names no source.
  assign set_mask = irq_in & ~NUM_VEC'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask & ~consume) | set_mask;
  end

  assign cpu_irq = pend & ~own;

endmodule

// File: rtl/dma_trigger_dispatch.sv
module dma_trigger_dispatch
  import dtd_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int VEC_W  = 6,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_in,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [7:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_CH-1:0]  dma_req,
  output logic [NUM_CH-1:0]  eot_irq,
  output logic [NUM_VEC-1:0] cpu_irq
);

  logic [NUM_CH-1:0][VEC_W-1:0] vec_w;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_w;
  logic [NUM_CH-1:0]            vec_wr_w, cnt_wr_w, last_w, armed_w, grant_w;
  logic [NUM_VEC-1:0]           pend_w, consume_w, own_w;
  logic                         clr_stb_w;
  logic [VEC_W-1:0]             clr_vec_w;

  dtd_regs #(
    .NUM_CH(NUM_CH), .VEC_W(VEC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .grant   (grant_w),
    .vec     (vec_w),
    .cnt     (cnt_w),
    .eot     (eot_irq),
    .vec_wr  (vec_wr_w),
    .cnt_wr  (cnt_wr_w),
    .last    (last_w),
    .clr_stb (clr_stb_w),
    .clr_vec (clr_vec_w),
    .rd_data (rd_data)
  );

  dtd_arbiter #(
    .NUM_CH(NUM_CH), .VEC_W(VEC_W), .CNT_W(CNT_W), .NUM_VEC(NUM_VEC)
  ) u_arb (
    .vec     (vec_w),
    .cnt     (cnt_w),
    .pend    (pend_w),
    .armed   (armed_w),
    .grant   (grant_w),
    .consume (consume_w),
    .own     (own_w)
  );

  dtd_flags #(
    .VEC_W(VEC_W), .NUM_VEC(NUM_VEC)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .clr_stb (clr_stb_w),
    .clr_vec (clr_vec_w),
    .consume (consume_w),
    .own     (own_w),
    .pend    (pend_w),
    .cpu_irq (cpu_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_req <= '0;
    else        dma_req <= grant_w;
  end

endmodule

// File: rtl/dtd_checker.sv
module dtd_checker #(
  parameter int NUM_CH  = 4,
  parameter int VEC_W   = 6,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_VEC = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_VEC-1:0]           irq_in,
  input logic [7:0]                   rd_addr,
  input logic [DATA_W-1:0]            rd_data,
  input logic [NUM_CH-1:0]            dma_req,
  input logic [NUM_CH-1:0]            eot_irq,
  input logic [NUM_CH-1:0]            grant,
  input logic [NUM_VEC-1:0]           consume,
  input logic [NUM_VEC-1:0]           pend,
  input logic [NUM_CH-1:0][VEC_W-1:0] vec,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]            vec_wr,
  input logic [NUM_CH-1:0]            cnt_wr
);

  // R6: every granted channel consumes a distinct vector.
  p_one_per_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(consume) == $countones(grant));

  // R1: the clear register never reads back.
  p_clr_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 8'h00) |-> (rd_data == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R4: a request lowers the count by one.
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req[c] && !$past(cnt_wr[c])) |-> (cnt[c] == CNT_W'($past(cnt[c]) - CNT_W'(1))));

    // R4: no request from an empty counter.
    p_no_empty_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> ($past(cnt[c]) != '0));

    // R5: a new end-of-transfer leaves the channel disarmed.
    p_eot_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eot_irq[c]) && !$past(vec_wr[c])) |-> (vec[c] == '0));
  end

  for (genvar n = 0; n < NUM_VEC; n++) begin : g_src
    // R8: a fresh request always leaves its flag set.
    p_irq_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((n != 0) && $past(irq_in[n])) |-> pend[n]);
  end

endmodule

bind dma_trigger_dispatch dtd_checker #(
  .NUM_CH(NUM_CH), .VEC_W(VEC_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_in  (irq_in),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .dma_req (dma_req),
  .eot_irq (eot_irq),
  .grant   (grant_w),
  .consume (consume_w),
  .pend    (pend_w),
  .vec     (vec_w),
  .cnt     (cnt_w),
  .vec_wr  (vec_wr_w),
  .cnt_wr  (cnt_wr_w)
);

// File: tb/test_dma_trigger_dispatch.sv
`timescale 1ns/1ps
module test_dma_trigger_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  dma_req, eot_irq;
  logic [63:0] cpu_irq;

  always #4 clk = ~clk;

  dma_trigger_dispatch i_dma_trigger_dispatch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dma_req(dma_req),
    .eot_irq(eot_irq), .cpu_irq(cpu_irq)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // Behavioural reference state.
  bit [63:0] m_pend;
  int        m_vec [4];
  int        m_cnt [4];
  bit [3:0]  m_eot;
  bit [3:0]  m_req;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_read(input int a);
    if (a >= 'h10 && a < 'h14) return m_vec[a-'h10];
    if (a >= 'h20 && a < 'h24) return m_cnt[a-'h20];
    if (a == 'h30) return int'(m_eot);
    return 0;
  endfunction

  function automatic bit [63:0] m_cpu();
    bit [63:0] r = m_pend;
    for (int c = 0; c < 4; c++)
      if (m_vec[c] != 0 && m_cnt[c] != 0) r[m_vec[c]] = 1'b0;
    return r;
  endfunction

  // Advance the model by one edge using the stimulus of this cycle.
  task automatic model_step(input bit [63:0] irq, input bit we, input int wa, input int wd);
    bit [63:0] taken = '0;
    bit [3:0]  g = '0;
    bit [63:0] np;
    for (int c = 0; c < 4; c++) begin
      if (m_vec[c] != 0 && m_cnt[c] != 0 && m_pend[m_vec[c]] && !taken[m_vec[c]]) begin
        g[c] = 1'b1;
        taken[m_vec[c]] = 1'b1;
      end
    end
    np = m_pend & ~taken;
    if (we && wa == 0 && (wd % 64) != 0) np[wd % 64] = 1'b0;
    np = np | (irq & ~64'd1);
    for (int c = 0; c < 4; c++) begin
      bit fin = g[c] && m_cnt[c] == 1;
      if (we && wa == 'h10 + c) m_vec[c] = wd % 64;
      else if (fin)             m_vec[c] = 0;
      if (we && wa == 'h20 + c) m_cnt[c] = wd % 65536;
      else if (g[c])            m_cnt[c] = m_cnt[c] - 1;
      if (fin)                             m_eot[c] = 1'b1;
      else if (we && wa == 'h30 && wd[c])  m_eot[c] = 1'b0;
    end
    m_pend = np;
    m_req  = g;
  endtask

  task automatic cyc(input bit [63:0] irq, input bit we, input int wa, input int wd);
    @(negedge clk);
    irq_in  = irq;
    wr_en   = we;
    wr_addr = 8'(wa);
    wr_data = 16'(wd);
    model_step(irq, we, wa, wd);
    @(posedge clk);
    #2;
    irq_in = '0;
    wr_en  = 1'b0;
    check(dma_req == m_req, "R3 dma_req", dma_req, m_req);
    check(eot_irq == m_eot, "R5 eot_irq", eot_irq, m_eot);
    check(cpu_irq == m_cpu(), "R2 cpu_irq", cpu_irq, m_cpu());
    check(int'(rd_data) == m_read(int'(rd_addr)), "R10 rd_data", rd_data, m_read(int'(rd_addr)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    cyc('0, 1, a, d);
  endtask

  function automatic bit [63:0] src(input int v);
    return 64'd1 << v;
  endfunction

  task automatic rd_chk(input int a, input int exp, input string tag);
    rd_addr = 8'(a);
    #1;
    check(int'(rd_data) == exp, tag, rd_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_vec[c] = 0; m_cnt[c] = 0; end
    m_pend = '0; m_eot = '0; m_req = '0;
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state
    check(dma_req == 0 && eot_irq == 0 && cpu_irq == 0, "R11 outputs after reset", {dma_req, eot_irq}, 0);
    rd_chk('h10, 0, "R11 vector after reset");
    rd_chk('h20, 0, "R11 count after reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2: unowned flag goes to the CPU; vector zero ignored.
    cyc(src(5) | src(0), 0, 0, 0);
    check(cpu_irq == src(5), "R2 unowned flag on cpu_irq", cpu_irq, src(5));
    // R1: writing zero to clear does nothing; writing 5 clears it.
    wr('h00, 0);
    check(cpu_irq[5] == 1'b1, "R1 clear of vector 0 has no effect", cpu_irq[5], 1);
    wr('h00, 5);
    check(cpu_irq[5] == 1'b0, "R1 clear by vector", cpu_irq[5], 0);
    rd_chk('h00, 0, "R1 clear register reads zero");

    // R8: clear and new request of 0x0A on one edge.
    cyc(src(10), 1, 'h00, 'h0A);
    check(cpu_irq[10] == 1'b1, "R8 request beats clear", cpu_irq[10], 1);
    wr('h00, 'h0A);
    check(cpu_irq[10] == 1'b0, "R1 clear of 0x0A", cpu_irq[10], 0);

    // R3/R4/R5: single channel, count 2.
    rd_addr = 'h20;
    wr('h10, 'h0A);
    wr('h20, 2);
    cyc(src(10), 0, 0, 0);
    idle(1);
    check(dma_req == 4'b0001, "R3 request to channel 0", dma_req, 1);
    rd_chk('h20, 1, "R4 count after one request");
    cyc(src(10), 0, 0, 0);
    idle(1);
    check(eot_irq[0] == 1'b1, "R5 end-of-transfer raised", eot_irq, 1);
    rd_chk('h10, 0, "R5 vector wiped at terminal count");
    idle(1);
    check(dma_req == 0, "R3 request is a single pulse", dma_req, 0);

    // R9: write-one-to-clear.
    wr('h30, 1);
    check(eot_irq[0] == 1'b0, "R9 end-of-transfer cleared", eot_irq, 0);

    // R6/R7: chaining on vector 7 across channels 1 and 2.
    wr('h11, 7); wr('h21, 1);
    wr('h12, 7); wr('h22, 2);
    cyc(src(7), 0, 0, 0);
    idle(1);
    check(dma_req == 4'b0010, "R6 lowest channel wins shared vector", dma_req, 2);
    rd_chk('h22, 2, "R6 higher channel count untouched");
    cyc(src(7), 0, 0, 0);
    idle(1);
    check(dma_req == 4'b0100, "R7 next channel takes over", dma_req, 4);

    // R6: different vectors fire together (ch2 on 7, ch3 on 9).
    wr('h13, 9); wr('h23, 1);
    cyc(src(7) | src(9), 0, 0, 0);
    idle(1);
    check(dma_req == 4'b1100, "R6 distinct vectors in one cycle", dma_req, 12);

    // R9: end-of-transfer set beats its clear.
    wr('h30, 'hF);
    wr('h13, 9); wr('h23, 1);
    cyc(src(9), 0, 0, 0);
    wr('h30, 8);
    check(eot_irq[3] == 1'b1, "R9 new end-of-transfer beats clear", eot_irq, 8);
    wr('h30, 8);
    check(eot_irq[3] == 1'b0, "R9 cleared afterwards", eot_irq, 0);

    // R10: vector rewrite on the terminal edge keeps the vector.
    wr('h11, 12); wr('h21, 1);
    cyc(src(12), 0, 0, 0);
    wr('h11, 12);
    rd_chk('h11, 12, "R10 software vector write wins");
    check(eot_irq[1] == 1'b1, "R5 terminal still signalled", eot_irq, 2);
    rd_chk('h44, 0, "R10 unmapped reads zero");

    // R8: consumption and a new request on the same edge.
    wr('h10, 'h0A); wr('h20, 3);
    cyc(src(10), 0, 0, 0);
    cyc(src(10), 0, 0, 0);
    check(dma_req == 4'b0001, "R3 first of back-to-back", dma_req, 1);
    idle(1);
    check(dma_req == 4'b0001, "R8 refilled flag issues again", dma_req, 1);
    rd_chk('h20, 1, "R4 count after two requests");
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule